// File: doc/BRIEF.md
# Receive FIFO Hysteresis Flow Control

This block drives the modem-control handshake pins of a UART receiver from the receive FIFO fill level. It uses two programmable limits to do this. When the level climbs to the upper limit, the block withdraws its ready-to-receive indication. It gives the indication again only after the level has drained strictly below the lower limit. The gap between the two limits is a hysteresis band, so the pin does not chatter while the level moves near one value.

Both handshake outputs can follow this one hold-off decision. The request-to-send output has its own enable bit. The data-terminal-ready output is chosen by a 2-bit mode. When automatic control is off, each output follows a software-written modem bit.

In the other direction, the block watches the peer's clear-to-send and data-set-ready inputs. Each has its own enable bit, and each can hold off the local transmitter. Both inputs pass through a synchronizer. The result is a plain transmit-permit level. The transmitter samples it only when it is about to start a new character, so a character already being shifted out always finishes.

The FIFO, the shift registers and the register decoding sit outside this block. All ports are plain control and status levels, so there is no valid/ready handshake and no back-pressure rule.

Top module: `rx_flow_ctrl`

## Requirements
- R1: While the fill level is at or above the upper limit, the hold-off state is set at the next clock edge. With automatic RTS on, `rts_n` is high (1) from that edge.
- R2: While the level lies between the limits (at or above the lower limit, below the upper limit), the hold-off state keeps its previous value.
- R3: When the level is strictly below the lower limit and below the upper limit, the hold-off state is cleared at the next edge. With automatic RTS on, `rts_n` returns low (0).
- R4: If the upper limit is not above the lower limit, the upper comparison wins. A level equal to or above the upper limit sets hold-off even when it is also below the lower limit.
- R5: `dtr_mode` encoding: 2'b00 gives `dtr_n = ~sw_dtr`; 2'b01 makes `dtr_n` follow the same hold-off state as automatic RTS; 2'b10 forces `dtr_n` low; 2'b11 forces it high.
- R6: With `rts_auto_en` = 0, `rts_n = ~sw_rts`, whatever the fill level.
- R7: With `cts_gate_en` = 1, `tx_permit` goes low in the second clock edge after `cts_n` goes high. It returns high two edges after `cts_n` goes low. With the gate off, `cts_n` has no effect on `tx_permit`.
- R8: With `dsr_gate_en` = 1, `dsr_n` gates `tx_permit` with the same two-edge latency. With the gate off, `dsr_n` has no effect.
- R9: Reset clears the hold-off state and the synchronizers. After reset, `rts_n` = 0 under automatic RTS, `dtr_n` = 0 in mode 2'b01, and `tx_permit` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| thr_hi | input | LVL_W | Upper limit; at or above it, flow is held off |
| thr_lo | input | LVL_W | Lower limit; strictly below it, flow resumes |
| rts_auto_en | input | 1 | Automatic RTS control enable |
| dtr_mode | input | 2 | DTR source select (see R5) |
| sw_rts | input | 1 | Software RTS bit, 1 = assert |
| sw_dtr | input | 1 | Software DTR bit, 1 = assert |
| cts_gate_en | input | 1 | Gate the transmitter on CTS# |
| dsr_gate_en | input | 1 | Gate the transmitter on DSR# |
| cts_n | input | 1 | Peer clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Peer data-set-ready, active low, asynchronous |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| tx_permit | output | 1 | 1 = transmitter may start a new character |

## Verification
The hardest case to reach is the inverted-limit case, where the upper limit sits at or below the lower one. Here both comparisons are true at the same time, and only the priority decides the outcome. The stimulus swaps the limits and sweeps the level up and back down through both of them.

A second subtle case is hold-off state built up while automatic RTS is disabled. That state must show up as soon as the enable returns. The bench fills the FIFO past the upper limit with the enable off, then turns the enable back on.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {
    DTR_SOFT  = 2'b00,
    DTR_AUTO  = 2'b01,
    DTR_FORCE_ON  = 2'b10,
    DTR_FORCE_OFF = 2'b11
  } dtr_sel_e;
endpackage

// File: rtl/rfc_hyst.sv
// Hysteresis comparator: the upper limit takes priority over the lower.
module rfc_hyst #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] hi,
  input  logic [LVL_W-1:0] lo,
  output logic             hold_off
);
  logic at_top, below_floor;

  always_comb begin
    at_top      = (level >= hi);
    below_floor = (level < lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold_off <= 1'b0;
    else if (at_top)      hold_off <= 1'b1;
    else if (below_floor) hold_off <= 1'b0;
  end
endmodule

// File: rtl/rfc_sync.sv
// Multi-stage synchronizer for an asynchronous pin; reset value is a parameter.
module rfc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rfc_pin_mux.sv
// Selects the source of each handshake output pin.
module rfc_pin_mux
  import rfc_pkg::*;
(
  input  logic     hold_off,
  input  logic     rts_auto_en,
  input  logic     sw_rts,
  input  dtr_sel_e dtr_sel,
  input  logic     sw_dtr,
  output logic     rts_n,
  output logic     dtr_n
);
  always_comb begin
    rts_n = rts_auto_en ? hold_off : ~sw_rts;
    unique case (dtr_sel)
      DTR_SOFT:      dtr_n = ~sw_dtr;
      DTR_AUTO:      dtr_n = hold_off;
      DTR_FORCE_ON:  dtr_n = 1'b0;
      DTR_FORCE_OFF: dtr_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
  import rfc_pkg::*;
#(
  parameter int LVL_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  input  logic             rts_auto_en,
  input  logic [1:0]       dtr_mode,
  input  logic             sw_rts,
  input  logic             sw_dtr,
  input  logic             cts_gate_en,
  input  logic             dsr_gate_en,
  input  logic             cts_n,
  input  logic             dsr_n,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             tx_permit
);
  localparam int NPEER = 2;

  logic             hold_off;
  logic [NPEER-1:0] peer_raw, peer_sync, peer_gate;

  rfc_hyst #(.LVL_W(LVL_W)) u_hyst (
    .clk(clk), .rst_n(rst_n), .level(rx_level),
    .hi(thr_hi), .lo(thr_lo), .hold_off(hold_off)
  );

  rfc_pin_mux u_mux (
    .hold_off(hold_off), .rts_auto_en(rts_auto_en), .sw_rts(sw_rts),
    .dtr_sel(dtr_sel_e'(dtr_mode)), .sw_dtr(sw_dtr),
    .rts_n(rts_n), .dtr_n(dtr_n)
  );

  assign peer_raw  = {dsr_n, cts_n};
  assign peer_gate = {dsr_gate_en, cts_gate_en};

  for (genvar g = 0; g < NPEER; g++) begin : g_peer
    rfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(peer_raw[g]), .q(peer_sync[g])
    );
  end

  // A peer that is gated and reports "not ready" (high) holds off new characters.
  assign tx_permit = ~|(peer_sync & peer_gate);
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] thr_hi,
  input logic [LVL_W-1:0] thr_lo,
  input logic             rts_auto_en,
  input logic [1:0]       dtr_mode,
  input logic             sw_rts,
  input logic             sw_dtr,
  input logic             cts_gate_en,
  input logic             dsr_gate_en,
  input logic             cts_n,
  input logic             dsr_n,
  input logic             rts_n,
  input logic             dtr_n,
  input logic             tx_permit
);
  // R1 / R4: reaching the upper limit holds off at the next edge
  a_r1_top_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto_en && rx_level >= thr_hi) |=> (rts_n || !rts_auto_en));

  // R2: inside the band a held-off pin stays high
  a_r2_band_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto_en && rts_n && rx_level >= thr_lo) |=> (rts_n || !rts_auto_en));

  // R3: strictly below the lower limit (and below the upper) releases
  a_r3_floor_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto_en && rx_level < thr_lo && rx_level < thr_hi) |=> (!rts_n || !rts_auto_en));

  // R5: automatic DTR tracks the same hold-off as automatic RTS
  a_r5_dtr_shares: assert property (@(posedge clk) disable iff (!rst_n)
    (dtr_mode == 2'b01 && rts_auto_en) |-> (dtr_n == rts_n));

  // R6: software RTS when automatic control is off
  a_r6_soft_rts: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_auto_en |-> (rts_n == !sw_rts));

  // R7 / R8: with both gates off the transmitter is always permitted
  a_r7_no_gate_permit: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_gate_en && !dsr_gate_en) |-> tx_permit);

  // R7: a gated CTS# held high for two edges blocks new characters
  a_r7_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_n && $past(cts_n) && cts_gate_en) |=> (!tx_permit || !cts_gate_en));
endmodule

bind rx_flow_ctrl rfc_checker #(.LVL_W(LVL_W)) u_rfc_checker (.*);

// File: tb/test_rx_flow_ctrl.sv
`timescale 1ns/1ps
module test_rx_flow_ctrl;
  localparam int LVL_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [LVL_W-1:0] rx_level, thr_hi, thr_lo;
  logic rts_auto_en, sw_rts, sw_dtr, cts_gate_en, dsr_gate_en, cts_n, dsr_n;
  logic [1:0] dtr_mode;
  logic rts_n, dtr_n, tx_permit;

  always #2.5 clk = ~clk;  // 200 MHz

  rx_flow_ctrl #(.LVL_W(LVL_W), .SYNC_STAGES(2)) i_rx_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .rts_auto_en(rts_auto_en), .dtr_mode(dtr_mode), .sw_rts(sw_rts), .sw_dtr(sw_dtr),
    .cts_gate_en(cts_gate_en), .dsr_gate_en(dsr_gate_en), .cts_n(cts_n), .dsr_n(dsr_n),
    .rts_n(rts_n), .dtr_n(dtr_n), .tx_permit(tx_permit)
  );

  int checks = 0;
  int fails  = 0;

  // Behavioural reference: a flag plus pin-history queues (two-edge latency).
  bit    m_stop;
  string m_tag;
  bit    cts_q[$];
  bit    dsr_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stop = 0; m_tag = "R9";
      cts_q.delete(); dsr_q.delete();
    end else begin
      if (int'(rx_level) >= int'(thr_hi)) begin
        m_stop = 1; m_tag = (thr_hi <= thr_lo) ? "R4" : "R1";
      end else if (int'(rx_level) < int'(thr_lo)) begin
        m_stop = 0; m_tag = "R3";
      end else m_tag = "R2";
      cts_q.push_back(cts_n); if (cts_q.size() > 2) void'(cts_q.pop_front());
      dsr_q.push_back(dsr_n); if (dsr_q.size() > 2) void'(dsr_q.pop_front());
    end
  end

  function automatic bit seen_pin(ref bit q[$]);
    return (q.size() == 2) ? q[0] : 1'b0;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_rts, e_dtr, e_perm;
    string t_rts, t_dtr;
    e_rts = rts_auto_en ? m_stop : !sw_rts;
    t_rts = rts_auto_en ? m_tag : "R6";
    case (dtr_mode)
      2'b00: begin e_dtr = !sw_dtr; t_dtr = "R5"; end
      2'b01: begin e_dtr = m_stop;  t_dtr = "R5"; end
      2'b10: begin e_dtr = 1'b0;    t_dtr = "R5"; end
      default: begin e_dtr = 1'b1;  t_dtr = "R5"; end
    endcase
    e_perm = !((cts_gate_en && seen_pin(cts_q)) || (dsr_gate_en && seen_pin(dsr_q)));
    chk(t_rts, rts_n, e_rts, "rts_n");
    chk(t_dtr, dtr_n, e_dtr, "dtr_n");
    chk((cts_gate_en || !dsr_gate_en) ? "R7" : "R8", tx_permit, e_perm, "tx_permit");
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic sweep(input int top);
    for (int l = 0; l <= top; l++) begin rx_level = LVL_W'(l); step(); end
    for (int l = top; l >= 0; l--) begin rx_level = LVL_W'(l); step(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; rx_level = '0; thr_hi = 8'd12; thr_lo = 8'd4;
    rts_auto_en = 1; dtr_mode = 2'b01; sw_rts = 0; sw_dtr = 0;
    cts_gate_en = 0; dsr_gate_en = 0; cts_n = 1; dsr_n = 1;
    repeat (3) @(negedge clk);
    // R9: reset values (pins asserted, permit high)
    chk("R9", rts_n, 1'b0, "rts_n after reset");
    chk("R9", dtr_n, 1'b0, "dtr_n after reset");
    chk("R9", tx_permit, 1'b1, "tx_permit after reset");
    rst_n = 1; cts_n = 0; dsr_n = 0;
    step(2);

    // R1 R2 R3: normal band, boundary levels 12 and 3/4 crossed both ways
    sweep(16);
    thr_hi = 8'd1; thr_lo = 8'd1; sweep(3);          // narrow band at the bottom

    // R4: inverted limits, both comparisons true at once
    thr_hi = 8'd5; thr_lo = 8'd8; sweep(10);
    thr_hi = 8'd12; thr_lo = 8'd4; rx_level = 8'd0; step(2);

    // R6: software RTS; hold-off built while disabled shows on re-enable
    rts_auto_en = 0;
    sw_rts = 1; step(2); sw_rts = 0; step(2);
    rx_level = 8'd13; step(2); sw_rts = 1; step(2);
    rts_auto_en = 1; step(2);                         // R1 state visible at once
    rx_level = 8'd6; step(2); rx_level = 8'd3; step(2);

    // R5: every DTR mode
    rx_level = 8'd20; step(2);
    dtr_mode = 2'b00; sw_dtr = 1; step(2); sw_dtr = 0; step(2);
    dtr_mode = 2'b10; step(2); dtr_mode = 2'b11; step(2);
    dtr_mode = 2'b01; step(2); rx_level = 8'd0; step(2);

    // R7: CTS gating latency, and no effect with gate off
    cts_n = 1; step(4); cts_n = 0; step(4);
    cts_gate_en = 1; step(2);
    cts_n = 1; step(1); step(1); step(2);
    cts_n = 0; step(3);
    cts_n = 1; step(1); cts_n = 0; step(3);          // one-cycle glitch
    cts_n = 1; step(3); cts_gate_en = 0; step(2); cts_gate_en = 1; step(2);
    cts_n = 0; step(3); cts_gate_en = 0;

    // R8: DSR gating, alone and together with CTS
    dsr_n = 1; step(3);
    dsr_gate_en = 1; step(3); dsr_n = 0; step(3);
    cts_gate_en = 1; cts_n = 1; dsr_n = 1; step(3);
    cts_n = 0; step(3); dsr_n = 0; step(3);
    dsr_gate_en = 0; cts_gate_en = 0; step(2);

    // R9: reset mid-run with FIFO full
    rx_level = 8'd30; step(2);
    rst_n = 0; #1;
    chk("R9", rts_n, 1'b0, "rts_n in reset");
    @(negedge clk); rx_level = 8'd0; rst_n = 1; step(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule